// File: doc/BRIEF.md
# Bit-Test Predicate Write Unit

This unit carries out a bit-test operation whose outcome lands in one-bit predicate registers. A 64-bit source value and a 6-bit position pick one bit. A zero or non-zero relation turns that bit into a one-bit result. A compare-type code then decides how the result, its complement or a constant goes to two destination predicates. The operation is presented for one cycle with `op_valid`. The write decision and the fault flag appear combinationally in the same cycle. The predicate file updates on the next rising clock edge.

The unit holds a 64-entry, one-bit predicate file. Entry 0 always reads one and cannot be written. For the normal and unconditional types, only the zero relation exists as logic. A non-zero request is served by exchanging the two destination indices on the write ports. When both destinations name the same register and the operation qualifies, or the type is unconditional, the unit raises `fault` and writes nothing.

The two read ports expose the file to the surrounding pipeline. The write ports show which entries are being updated.

Top module: `tbit_pred_unit`

## Requirements
- R1: The tested bit is `src_val[bit_pos]` for every position from 0 to 63.
- R2: With `rel_nz`=1 the result equals the tested bit. With `rel_nz`=0 the result is the inverted bit.
- R3: Compare-type code 0 (normal), qualifier 1: the first destination receives the result and the second receives its complement. With qualifier 0, nothing is written.
- R4: Code 1 (unconditional), qualifier 0: both destinations are cleared. With qualifier 1 it acts as code 0.
- R5: Code 2 (parallel and): with qualifier 1 and result 0, both destinations are cleared. In every other case nothing is written.
- R6: Code 3 (parallel or): with qualifier 1 and result 1, both destinations are set. In every other case nothing is written.
- R7: Code 4 (or with and-complement): with qualifier 1 and result 1, the first destination is set and the second is cleared. In every other case nothing is written.
- R8: Code 5 (and with or-complement): with qualifier 1 and result 0, the first destination is cleared and the second is set. In every other case nothing is written.
- R9: `fault` is 1 when `op_valid`=1, `dst_a`==`dst_b`, and either the qualifier is 1 or the code is 1. In that case no predicate is written.
- R10: Predicate 0 always reads 1, and writes aimed at it have no effect.
- R11: A write is visible on the read ports after the next rising edge. Reset clears entries 1 to 63 to 0.
- R12: Codes 6 and 7 write nothing.
- R13: For codes 0 and 1 with `rel_nz`=1, the write ports carry the destinations exchanged. `wr_idx_a` is `dst_b` and `wr_idx_b` is `dst_a`, and the ports carry the zero-relation data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| src_val | input | 64 | Source register value |
| bit_pos | input | 6 | Position of the tested bit |
| rel_nz | input | 1 | 1 = non-zero relation, 0 = zero relation |
| ctype | input | 3 | Compare-type code (0..5, 6..7 reserved) |
| qual | input | 1 | Qualifying predicate value |
| dst_a | input | 6 | First destination predicate index |
| dst_b | input | 6 | Second destination predicate index |
| rd_idx_a | input | 6 | Read port A index |
| rd_idx_b | input | 6 | Read port B index |
| fault | output | 1 | Illegal-operation fault |
| wr_en_a | output | 1 | Write port A enable |
| wr_idx_a | output | 6 | Write port A index |
| wr_dat_a | output | 1 | Write port A data |
| wr_en_b | output | 1 | Write port B enable |
| wr_idx_b | output | 6 | Write port B index |
| wr_dat_b | output | 1 | Write port B data |
| rd_val_a | output | 1 | Predicate at `rd_idx_a` |
| rd_val_b | output | 1 | Predicate at `rd_idx_b` |

## Verification
`fault` and the write-port outputs are due in the cycle the operation is presented. The bench samples them 2 ns after the falling edge on which it drove the inputs. The predicate values are due one rising edge later. The monitor therefore waits for the next falling edge, drops `op_valid`, points both read ports at the destinations and compares 2 ns later against a bench-side predicate model. The driver does not present a new operation until the monitor has drained the expected item.

// File: rtl/tbit_pkg.sv
package tbit_pkg;

    typedef enum logic [2:0] {
        CT_NORMAL   = 3'd0,
        CT_UNCOND   = 3'd1,
        CT_PAR_AND  = 3'd2,
        CT_PAR_OR   = 3'd3,
        CT_OR_ANDCM = 3'd4,
        CT_AND_ORCM = 3'd5
    } ctype_e;

endpackage

// File: rtl/tbit_bit_pick.sv
module tbit_bit_pick #(
    parameter int DATA_W = 64,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [POS_W-1:0]  pos_i,
    output logic              bit_o
);

    always_comb begin
        bit_o = src_i[pos_i];
    end

endmodule

// File: rtl/tbit_dest_ctrl.sv
module tbit_dest_ctrl
    import tbit_pkg::*;
#(
    parameter int NPRED = 64,
    localparam int IDX_W = $clog2(NPRED)
) (
    input  logic             valid_i,
    input  logic             bit_i,
    input  logic             rel_nz_i,
    input  logic [2:0]       ctype_i,
    input  logic             qual_i,
    input  logic [IDX_W-1:0] dst_a_i,
    input  logic [IDX_W-1:0] dst_b_i,
    output logic             fault_o,
    output logic             en_a_o,
    output logic [IDX_W-1:0] idx_a_o,
    output logic             dat_a_o,
    output logic             en_b_o,
    output logic [IDX_W-1:0] idx_b_o,
    output logic             dat_b_o
);

    ctype_e ct;
    logic   swap;
    logic   z_res;
    logic   par_res;
    logic   same_dst;
    logic   en_a_raw, en_b_raw;

    assign ct = ctype_e'(ctype_i);

    // Normal and unconditional types only carry the zero relation;
    // a non-zero request exchanges the destinations instead.
    always_comb begin
        swap     = ((ct == CT_NORMAL) || (ct == CT_UNCOND)) && rel_nz_i;
        idx_a_o  = swap ? dst_b_i : dst_a_i;
        idx_b_o  = swap ? dst_a_i : dst_b_i;
        z_res    = ~bit_i;
        par_res  = rel_nz_i ? bit_i : ~bit_i;
        same_dst = (dst_a_i == dst_b_i);
        fault_o  = valid_i && same_dst && (qual_i || (ct == CT_UNCOND));
    end

    always_comb begin
        en_a_raw = 1'b0;
        en_b_raw = 1'b0;
        dat_a_o  = 1'b0;
        dat_b_o  = 1'b0;
        unique case (ct)
            CT_NORMAL: begin
                if (qual_i) begin
                    en_a_raw = 1'b1;
                    en_b_raw = 1'b1;
                    dat_a_o  = z_res;
                    dat_b_o  = ~z_res;
                end
            end
            CT_UNCOND: begin
                en_a_raw = 1'b1;
                en_b_raw = 1'b1;
                if (qual_i) begin
                    dat_a_o = z_res;
                    dat_b_o = ~z_res;
                end
            end
            CT_PAR_AND: begin
                if (qual_i && !par_res) begin
                    en_a_raw = 1'b1;
                    en_b_raw = 1'b1;
                end
            end
            CT_PAR_OR: begin
                if (qual_i && par_res) begin
                    en_a_raw = 1'b1;
                    en_b_raw = 1'b1;
                    dat_a_o  = 1'b1;
                    dat_b_o  = 1'b1;
                end
            end
            CT_OR_ANDCM: begin
                if (qual_i && par_res) begin
                    en_a_raw = 1'b1;
                    en_b_raw = 1'b1;
                    dat_a_o  = 1'b1;
                end
            end
            CT_AND_ORCM: begin
                if (qual_i && !par_res) begin
                    en_a_raw = 1'b1;
                    en_b_raw = 1'b1;
                    dat_b_o  = 1'b1;
                end
            end
            default: begin
                en_a_raw = 1'b0;
                en_b_raw = 1'b0;
            end
        endcase
    end

    assign en_a_o = valid_i && !fault_o && en_a_raw;
    assign en_b_o = valid_i && !fault_o && en_b_raw;

endmodule

// File: rtl/tbit_pred_file.sv
module tbit_pred_file #(
    parameter int NPRED = 64,
    localparam int IDX_W = $clog2(NPRED)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_a,
    input  logic [IDX_W-1:0] wi_a,
    input  logic             wd_a,
    input  logic             we_b,
    input  logic [IDX_W-1:0] wi_b,
    input  logic             wd_b,
    input  logic [IDX_W-1:0] ri_a,
    input  logic [IDX_W-1:0] ri_b,
    output logic             rv_a,
    output logic             rv_b
);

    logic [NPRED-1:0] preds;

    for (genvar i = 0; i < NPRED; i++) begin : g_ent
        if (i == 0) begin : g_hard
            assign preds[i] = 1'b1;
        end else begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    preds[i] <= 1'b0;
                end else if (we_a && (wi_a == IDX_W'(i))) begin
                    preds[i] <= wd_a;
                end else if (we_b && (wi_b == IDX_W'(i))) begin
                    preds[i] <= wd_b;
                end
            end
        end
    end

    assign rv_a = preds[ri_a];
    assign rv_b = preds[ri_b];

endmodule

// File: rtl/tbit_pred_unit.sv
module tbit_pred_unit #(
    parameter int DATA_W = 64,
    parameter int NPRED  = 64,
    localparam int POS_W = $clog2(DATA_W),
    localparam int IDX_W = $clog2(NPRED)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] src_val,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic              rel_nz,
    input  logic [2:0]        ctype,
    input  logic              qual,
    input  logic [IDX_W-1:0]  dst_a,
    input  logic [IDX_W-1:0]  dst_b,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic              fault,
    output logic              wr_en_a,
    output logic [IDX_W-1:0]  wr_idx_a,
    output logic              wr_dat_a,
    output logic              wr_en_b,
    output logic [IDX_W-1:0]  wr_idx_b,
    output logic              wr_dat_b,
    output logic              rd_val_a,
    output logic              rd_val_b
);

    logic sel_bit;

    tbit_bit_pick #(.DATA_W(DATA_W)) u_pick (
        .src_i (src_val),
        .pos_i (bit_pos),
        .bit_o (sel_bit)
    );

    tbit_dest_ctrl #(.NPRED(NPRED)) u_ctrl (
        .valid_i  (op_valid),
        .bit_i    (sel_bit),
        .rel_nz_i (rel_nz),
        .ctype_i  (ctype),
        .qual_i   (qual),
        .dst_a_i  (dst_a),
        .dst_b_i  (dst_b),
        .fault_o  (fault),
        .en_a_o   (wr_en_a),
        .idx_a_o  (wr_idx_a),
        .dat_a_o  (wr_dat_a),
        .en_b_o   (wr_en_b),
        .idx_b_o  (wr_idx_b),
        .dat_b_o  (wr_dat_b)
    );

    tbit_pred_file #(.NPRED(NPRED)) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .we_a  (wr_en_a),
        .wi_a  (wr_idx_a),
        .wd_a  (wr_dat_a),
        .we_b  (wr_en_b),
        .wi_b  (wr_idx_b),
        .wd_b  (wr_dat_b),
        .ri_a  (rd_idx_a),
        .ri_b  (rd_idx_b),
        .rv_a  (rd_val_a),
        .rv_b  (rd_val_b)
    );

endmodule

// File: rtl/tbit_pred_unit_chk.sv
module tbit_pred_unit_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             rel_nz,
    input logic [2:0]       ctype,
    input logic             qual,
    input logic [IDX_W-1:0] dst_a,
    input logic [IDX_W-1:0] dst_b,
    input logic [IDX_W-1:0] rd_idx_a,
    input logic             fault,
    input logic             wr_en_a,
    input logic [IDX_W-1:0] wr_idx_a,
    input logic             wr_dat_a,
    input logic             wr_en_b,
    input logic [IDX_W-1:0] wr_idx_b,
    input logic             wr_dat_b,
    input logic             rd_val_a
);

    AST_FAULT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!wr_en_a && !wr_en_b)); // R9

    AST_SAME_DEST_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (dst_a == dst_b) && qual) |-> fault); // R9

    AST_P0_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_a == '0) |-> rd_val_a); // R10

    AST_UNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ctype == 3'd1 && !qual && dst_a != dst_b)
            |-> (wr_en_a && wr_en_b && !wr_dat_a && !wr_dat_b)); // R4

    AST_NORMAL_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ctype == 3'd0 && wr_en_a) |-> (wr_dat_b == !wr_dat_a)); // R3

    AST_OR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ctype == 3'd3 && wr_en_a) |-> (wr_dat_a && wr_dat_b)); // R6

    AST_RESERVED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctype[2:1] == 2'b11) |-> (!wr_en_a && !wr_en_b)); // R12

    AST_NZ_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ctype == 3'd0 && rel_nz && qual && !fault)
            |-> (wr_idx_a == dst_b && wr_idx_b == dst_a)); // R13

    AST_COMMIT_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_a && wr_idx_a != '0 && rd_idx_a == wr_idx_a)
            |=> ((rd_idx_a != $past(rd_idx_a)) || (rd_val_a == $past(wr_dat_a)))); // R11

endmodule

bind tbit_pred_unit tbit_pred_unit_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .rel_nz   (rel_nz),
    .ctype    (ctype),
    .qual     (qual),
    .dst_a    (dst_a),
    .dst_b    (dst_b),
    .rd_idx_a (rd_idx_a),
    .fault    (fault),
    .wr_en_a  (wr_en_a),
    .wr_idx_a (wr_idx_a),
    .wr_dat_a (wr_dat_a),
    .wr_en_b  (wr_en_b),
    .wr_idx_b (wr_idx_b),
    .wr_dat_b (wr_dat_b),
    .rd_val_a (rd_val_a)
);

// File: tb/tbit_pred_unit_tb.sv
`timescale 1ns/1ps
module tbit_pred_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] src_val = '0;
    logic [5:0]  bit_pos = '0;
    logic        rel_nz = 1'b0;
    logic [2:0]  ctype = '0;
    logic        qual = 1'b0;
    logic [5:0]  dst_a = '0, dst_b = '0;
    logic [5:0]  rd_idx_a = '0, rd_idx_b = '0;
    logic        fault, wr_en_a, wr_dat_a, wr_en_b, wr_dat_b, rd_val_a, rd_val_b;
    logic [5:0]  wr_idx_a, wr_idx_b;

    always #10 clk = ~clk;

    tbit_pred_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .src_val(src_val),
        .bit_pos(bit_pos), .rel_nz(rel_nz), .ctype(ctype), .qual(qual),
        .dst_a(dst_a), .dst_b(dst_b), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
        .fault(fault), .wr_en_a(wr_en_a), .wr_idx_a(wr_idx_a), .wr_dat_a(wr_dat_a),
        .wr_en_b(wr_en_b), .wr_idx_b(wr_idx_b), .wr_dat_b(wr_dat_b),
        .rd_val_a(rd_val_a), .rd_val_b(rd_val_b)
    );

    typedef struct {
        string      tag;
        logic [5:0] ia, ib;
        logic       ea, eb, efault;
        logic       chk_port;
        logic [5:0] e_widx_a;
    } item_t;

    item_t q[$];
    logic  model [64];
    int    n_chk = 0;
    int    n_fail = 0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [63:0] s, input int pos,
                          input logic nz, input int ct, input logic qp,
                          input int a, input int b, input logic chk_port);
        item_t it;
        logic  bv, r, f, wa, wb, va, vb;
        bv = s[pos];
        r  = nz ? bv : ~bv;
        f  = (a == b) && (qp || ct == 1);
        wa = 1'b0; wb = 1'b0; va = 1'b0; vb = 1'b0;
        if (!f) begin
            case (ct)
                0: if (qp) begin wa = 1; wb = 1; va = r; vb = ~r; end
                1: begin wa = 1; wb = 1; va = qp ? r : 1'b0; vb = qp ? ~r : 1'b0; end
                2: if (qp && !r) begin wa = 1; wb = 1; end
                3: if (qp && r) begin wa = 1; wb = 1; va = 1; vb = 1; end
                4: if (qp && r) begin wa = 1; wb = 1; va = 1; end
                5: if (qp && !r) begin wa = 1; wb = 1; vb = 1; end
                default: ;
            endcase
        end
        if (wa && a != 0) model[a] = va;
        if (wb && b != 0) model[b] = vb;
        it.tag = tag; it.ia = 6'(a); it.ib = 6'(b);
        it.ea = model[a]; it.eb = model[b]; it.efault = f;
        it.chk_port = chk_port;
        it.e_widx_a = (nz && (ct == 0 || ct == 1)) ? 6'(b) : 6'(a);
        @(negedge clk);
        src_val = s; bit_pos = 6'(pos); rel_nz = nz; ctype = 3'(ct);
        qual = qp; dst_a = 6'(a); dst_b = 6'(b); op_valid = 1'b1;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            wait (q.size() != 0);
            it = q[0];
            #2;
            check({it.tag, " fault"}, 8'(fault), 8'(it.efault));
            if (it.chk_port) check({it.tag, " wr_idx_a"}, 8'(wr_idx_a), 8'(it.e_widx_a));
            @(negedge clk);
            op_valid = 1'b0;
            rd_idx_a = it.ia;
            rd_idx_b = it.ib;
            #2;
            check({it.tag, " pred a"}, 8'(rd_val_a), 8'(it.ea));
            check({it.tag, " pred b"}, 8'(rd_val_b), 8'(it.eb));
            void'(q.pop_front());
        end
    end

    task automatic main_seq();
        for (int i = 0; i < 64; i++) model[i] = (i == 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_idx_a = 6'd0; rd_idx_b = 6'd7;
        @(negedge clk); #2;
        check("R10 reset p0", 8'(rd_val_a), 8'd1);
        check("R11 reset p7", 8'(rd_val_b), 8'd0);
        // parallel or / and
        run_op("R6 or sets",        64'h8, 3, 1, 3, 1, 5, 6, 0);
        run_op("R6 or no write",    64'h8, 4, 1, 3, 1, 7, 8, 0);
        run_op("R5 and clears",     64'h8, 3, 0, 2, 1, 5, 6, 0);
        run_op("R6 or preset",      64'h1, 0, 1, 3, 1, 9, 10, 0);
        run_op("R5 and no write",   64'h8, 3, 1, 2, 1, 9, 10, 0);
        // normal, bit 63, both relations
        run_op("R1 R2 R3 normal z", 64'h8000_0000_0000_0000, 63, 0, 0, 1, 11, 12, 1);
        run_op("R13 normal nz",     64'h8000_0000_0000_0000, 63, 1, 0, 1, 11, 12, 1);
        run_op("R3 normal qp0",     64'h0, 0, 0, 0, 0, 11, 12, 0);
        // unconditional
        run_op("R4 unc qp0 clears", 64'h1, 0, 1, 1, 0, 11, 12, 0);
        run_op("R4 R13 unc nz",     64'h1, 0, 1, 1, 1, 13, 14, 1);
        // mixed parallel
        run_op("R7 or.andcm",       64'h4, 2, 1, 4, 1, 15, 16, 0);
        run_op("R7 or.andcm idle",  64'h0, 2, 1, 4, 1, 15, 16, 0);
        run_op("R8 and.orcm",       64'h0, 5, 1, 5, 1, 17, 18, 0);
        // faults
        run_op("R9 same dst qp1",   64'h0, 1, 0, 0, 1, 12, 12, 0);
        run_op("R9 same dst unc",   64'h0, 1, 0, 1, 0, 18, 18, 0);
        run_op("R9 same dst quiet", 64'h0, 1, 0, 0, 0, 18, 18, 0);
        run_op("R9 or same qp1",    64'hFF, 1, 1, 3, 1, 20, 20, 0);
        // predicate 0
        run_op("R10 write p0",      64'h0, 9, 0, 0, 1, 0, 20, 0);
        // reserved codes
        run_op("R12 preset",        64'h2, 1, 1, 3, 1, 21, 22, 0);
        run_op("R12 code 6",        64'h0, 1, 0, 6, 1, 21, 22, 0);
        run_op("R12 code 7",        64'h0, 1, 0, 7, 1, 21, 22, 0);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule